// File: doc/BRIEF.md
# SCSI Initiator Bus Arbiter

This block runs the arbitration step for a SCSI initiator. Software raises an arbitrate request level. A rising edge of that level starts one attempt. If another device already drives SEL and this device is not driving SEL itself, the attempt fails at once. Otherwise the block puts its own ID pattern onto the data bus, raises BSY, and waits for a fixed arbitration time.

When the wait ends, the block reads the wired-OR data bus and picks the highest set bit as the winner. If the winner matches its own ID, the block keeps holding the bus. If not, it lets go of the bus and reports a loss. Two status flags report the outcome: one for "arbitration in progress" and one for "arbitration lost".

The wait is a base of eleven units scaled by a clock-conversion factor. The factor is loaded through a write strobe and returns to 2 on reset. Clearing the request level aborts an attempt that is still waiting. Clearing it also gives up a bus that has already been won.

Top module: `scsi_arb_unit`

## Requirements
- R1: After reset, data_out is 0, and data_oe, bsy_out, arb_busy and arb_lost are all 0. The conversion factor is 2.
- R2: An attempt starts only on a 0-to-1 change of arb_req, sampled on the clock. Holding arb_req high never starts a second attempt, even after a failed attempt or while the bus is held.
- R3: An attempt fails at once when bus_sel_in=1 and own_sel_assert=0 at the start edge. In the next cycle arb_lost=1, arb_busy=0, and bsy_out and data_oe stay 0.
- R4: When bus_sel_in=1 and own_sel_assert=1, the attempt goes ahead exactly as if SEL were absent.
- R5: On an attempt that goes ahead, in the cycle after the start edge: arb_lost=0, arb_busy=1, bsy_out=1, data_oe=1, and data_out equals the value out_latch had at the start edge.
- R6: The outcome is decided on the clock edge N+1 cycles after the start edge, where N = 11 × factor. arb_busy stays 1 up to and including the cycle after edge N. conv_we=1 loads conv_in as the new factor. The new factor applies to attempts that start later.
- R7: The winner is the index of the highest set bit of bus_data_in, with bit 7 the highest priority. If the winner equals own_id, then after the decision arb_busy=0, arb_lost=0, and bsy_out, data_oe and data_out stay as they were.
- R8: If a higher bit than own_id is set, or bus_data_in is 0 at the decision, the block drops bsy_out and data_oe, sets data_out to 0, sets arb_lost=1 and clears arb_busy. arb_busy and arb_lost are never 1 at the same time.
- R9: If arb_req is 0 during the wait, the next edge ends the attempt. bsy_out, data_oe and arb_busy go to 0, and arb_lost stays 0.
- R10: With a factor of 0, the outcome is decided on the first clock edge after the start edge.
- R11: While the bus is held after a win, arb_req=0 releases bsy_out and data_oe on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_req | input | 1 | Arbitrate request level; a rising edge starts an attempt |
| own_id | input | 3 | This device's bus ID |
| out_latch | input | 8 | Output data latch driven onto the bus during arbitration |
| bus_data_in | input | 8 | Observed wired-OR SCSI data bus |
| bus_sel_in | input | 1 | Observed SEL line |
| own_sel_assert | input | 1 | This device is itself asserting SEL |
| conv_we | input | 1 | Load strobe for the conversion factor |
| conv_in | input | 4 | New conversion factor |
| data_out | output | 8 | Data driven onto the bus |
| data_oe | output | 1 | Data bus drive enable |
| bsy_out | output | 1 | BSY drive |
| arb_busy | output | 1 | Arbitration in progress flag |
| arb_lost | output | 1 | Arbitration lost flag |

## Verification
The bench models the shared data bus as the OR of this block's driven pattern and the bits of other devices. It then walks cases where the winner lies above, below or exactly on the block's own bit, plus an empty bus. A priority encoder that favours bit 0 would hand wins to the wrong device. A design that checks SEL without looking at its own SEL-assert bit would refuse a legal attempt.

The bench counts the wait to the exact edge, for the default factor, a factor of one and a factor of zero. An off-by-one counter, or one that underflows on zero, shows up as a decision that is early, late or never comes.

Three more cases target the request level itself. A level that stays high must not restart arbitration. Clearing the level must abort a pending wait, and it must also free a bus that was already won. A level-triggered start, or an FSM that ignores arb_req while waiting, fails these checks.

// File: rtl/scsi_arb_pkg.sv
package scsi_arb_pkg;
    localparam int DEF_BUS_W      = 8;
    localparam int DEF_CONV_W     = 4;
    localparam int DEF_WAIT_UNITS = 11;
    localparam int DEF_CONV_RESET = 2;

    typedef enum logic [1:0] {
        ARB_IDLE,
        ARB_WAIT,
        ARB_HELD
    } arb_state_e;

    typedef struct packed {
        logic busy;
        logic lost;
    } arb_flags_t;

    function automatic int cnt_width(input int units, input int conv_w);
        return $clog2(units * ((1 << conv_w) - 1) + 1) + 1;
    endfunction
endpackage

// File: rtl/scsi_arb_prio.sv
module scsi_arb_prio #(
    parameter int BUS_W = 8,
    localparam int ID_W = $clog2(BUS_W)
) (
    input  logic [BUS_W-1:0] bus,
    output logic             valid,
    output logic [ID_W-1:0]  idx
);
    logic [BUS_W-1:0] top_bit;

    genvar g;
    generate
        for (g = 0; g < BUS_W; g++) begin : g_bit
            if (g == BUS_W - 1) begin : g_top
                assign top_bit[g] = bus[g];
            end else begin : g_low
                assign top_bit[g] = bus[g] & ~(|bus[BUS_W-1:g+1]);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < BUS_W; i++) begin
            if (top_bit[i]) idx = ID_W'(i);
        end
    end

    assign valid = |bus;

    // R7
    always_comb begin
        prio_onehot_chk: assert ($onehot0(top_bit));
    end
endmodule

// File: rtl/scsi_arb_timer.sv
module scsi_arb_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R6
    timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && expired) |=> expired);

    // R6
    timer_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/scsi_arb_unit.sv
module scsi_arb_unit #(
    parameter int BUS_W      = scsi_arb_pkg::DEF_BUS_W,
    parameter int CONV_W     = scsi_arb_pkg::DEF_CONV_W,
    parameter int WAIT_UNITS = scsi_arb_pkg::DEF_WAIT_UNITS,
    parameter int CONV_RESET = scsi_arb_pkg::DEF_CONV_RESET,
    localparam int ID_W      = $clog2(BUS_W),
    localparam int CNT_W     = scsi_arb_pkg::cnt_width(WAIT_UNITS, CONV_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arb_req,
    input  logic [ID_W-1:0]   own_id,
    input  logic [BUS_W-1:0]  out_latch,
    input  logic [BUS_W-1:0]  bus_data_in,
    input  logic              bus_sel_in,
    input  logic              own_sel_assert,
    input  logic              conv_we,
    input  logic [CONV_W-1:0] conv_in,
    output logic [BUS_W-1:0]  data_out,
    output logic              data_oe,
    output logic              bsy_out,
    output logic              arb_busy,
    output logic              arb_lost
);
    import scsi_arb_pkg::*;

    arb_state_e        state_q;
    arb_flags_t        flags_q;
    logic              req_q;
    logic              drive_q;
    logic [BUS_W-1:0]  data_q;
    logic [CONV_W-1:0] conv_q;

    logic              start;
    logic              conflict;
    logic              tmr_load;
    logic              tmr_expired;
    logic [CNT_W-1:0]  tmr_len;
    logic              win_valid;
    logic [ID_W-1:0]   win_idx;
    logic              we_win;

    assign start    = arb_req & ~req_q;
    assign conflict = bus_sel_in & ~own_sel_assert;
    assign tmr_load = (state_q == ARB_IDLE) && start && !conflict;
    assign tmr_len  = CNT_W'(WAIT_UNITS) * CNT_W'(conv_q);
    assign we_win   = win_valid && (win_idx == own_id);

    scsi_arb_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_len),
        .expired  (tmr_expired)
    );

    scsi_arb_prio #(.BUS_W(BUS_W)) prio_i (
        .bus   (bus_data_in),
        .valid (win_valid),
        .idx   (win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            flags_q <= '0;
            req_q   <= 1'b0;
            drive_q <= 1'b0;
            data_q  <= '0;
            conv_q  <= CONV_W'(CONV_RESET);
        end else begin
            req_q <= arb_req;
            if (conv_we) conv_q <= conv_in;
            unique case (state_q)
                ARB_IDLE: begin
                    if (start) begin
                        if (conflict) begin
                            flags_q.lost <= 1'b1;
                            flags_q.busy <= 1'b0;
                        end else begin
                            flags_q.lost <= 1'b0;
                            flags_q.busy <= 1'b1;
                            drive_q      <= 1'b1;
                            data_q       <= out_latch;
                            state_q      <= ARB_WAIT;
                        end
                    end
                end
                ARB_WAIT: begin
                    if (!arb_req) begin
                        flags_q.busy <= 1'b0;
                        drive_q      <= 1'b0;
                        data_q       <= '0;
                        state_q      <= ARB_IDLE;
                    end else if (tmr_expired) begin
                        flags_q.busy <= 1'b0;
                        if (we_win) begin
                            state_q <= ARB_HELD;
                        end else begin
                            flags_q.lost <= 1'b1;
                            drive_q      <= 1'b0;
                            data_q       <= '0;
                            state_q      <= ARB_IDLE;
                        end
                    end
                end
                ARB_HELD: begin
                    if (!arb_req) begin
                        drive_q <= 1'b0;
                        data_q  <= '0;
                        state_q <= ARB_IDLE;
                    end
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    assign data_out = data_q;
    assign data_oe  = drive_q;
    assign bsy_out  = drive_q;
    assign arb_busy = flags_q.busy;
    assign arb_lost = flags_q.lost;

    // R3
    sel_conflict_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_IDLE && start && conflict) |=> (arb_lost && !arb_busy && !bsy_out));

    // R5
    start_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_IDLE && start && !conflict)
        |=> (arb_busy && !arb_lost && bsy_out && data_out == $past(out_latch)));

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(arb_busy && arb_lost));

    // R9
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_WAIT && !arb_req) |=> (!bsy_out && !arb_busy));

    // R7
    win_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_WAIT && arb_req && tmr_expired && we_win)
        |=> (bsy_out && !arb_busy && !arb_lost && $stable(data_out)));

    // R11
    held_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_HELD && !arb_req) |=> !bsy_out);
endmodule

// File: tb/scsi_arb_unit_tb.sv
module scsi_arb_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       arb_req;
    logic [2:0] own_id;
    logic [7:0] out_latch;
    logic [7:0] others;
    logic [7:0] bus_data_in;
    logic       bus_sel_in;
    logic       own_sel_assert;
    logic       conv_we;
    logic [3:0] conv_in;
    logic [7:0] data_out;
    logic       data_oe;
    logic       bsy_out;
    logic       arb_busy;
    logic       arb_lost;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    assign bus_data_in = (data_oe ? data_out : 8'h00) | others;

    scsi_arb_unit dut_i (
        .clk(clk), .rst(rst), .arb_req(arb_req), .own_id(own_id),
        .out_latch(out_latch), .bus_data_in(bus_data_in),
        .bus_sel_in(bus_sel_in), .own_sel_assert(own_sel_assert),
        .conv_we(conv_we), .conv_in(conv_in), .data_out(data_out),
        .data_oe(data_oe), .bsy_out(bsy_out), .arb_busy(arb_busy),
        .arb_lost(arb_lost)
    );

    // outcome: 0 = win, 1 = lost after wait, 2 = immediate SEL conflict
    typedef struct packed {
        logic [2:0] id;
        logic [7:0] latch;
        logic [7:0] oth;
        logic       sel;
        logic       osel;
        logic [1:0] outcome;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{3'd7, 8'h80, 8'h05, 1'b0, 1'b0, 2'd0},
        '{3'd3, 8'h08, 8'h10, 1'b0, 1'b0, 2'd1},
        '{3'd0, 8'h01, 8'h00, 1'b0, 1'b0, 2'd0},
        '{3'd5, 8'h20, 8'h80, 1'b0, 1'b0, 2'd1},
        '{3'd2, 8'h04, 8'h00, 1'b1, 1'b0, 2'd2},
        '{3'd2, 8'h04, 8'h03, 1'b1, 1'b1, 2'd0},
        '{3'd4, 8'h00, 8'h00, 1'b0, 1'b0, 2'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_req();
        @(negedge clk);
        arb_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Raise arb_req and stop just after the start edge
    task automatic raise_req();
        arb_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_wait(input string tag, input int n);
        repeat (n) @(negedge clk);
        chk({tag, " busy before decision"}, arb_busy, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; arb_req = 1'b0; own_id = 3'd0; out_latch = 8'h00; others = 8'h00;
        bus_sel_in = 1'b0; own_sel_assert = 1'b0; conv_we = 1'b0; conv_in = 4'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 data_out", data_out, 0);
        chk("R1 bsy_out", bsy_out, 0);
        chk("R1 data_oe", data_oe, 0);
        chk("R1 arb_busy", arb_busy, 0);
        chk("R1 arb_lost", arb_lost, 0);

        // Vector walk with default factor 2 (R1 factor, R6 N=22)
        foreach (VECS[k]) begin
            own_id = VECS[k].id; out_latch = VECS[k].latch; others = VECS[k].oth;
            bus_sel_in = VECS[k].sel; own_sel_assert = VECS[k].osel;
            raise_req();
            if (VECS[k].outcome == 2'd2) begin
                chk("R3 lost", arb_lost, 1);
                chk("R3 busy", arb_busy, 0);
                chk("R3 bsy_out", bsy_out, 0);
            end else begin
                chk("R5 busy", arb_busy, 1);
                chk("R5 lost", arb_lost, 0);
                chk("R5 bsy_out", bsy_out, 1);
                chk("R5 data_out", data_out, VECS[k].latch);
                run_wait("R6", 22);
                chk("R6 busy after decision", arb_busy, 0);
                if (VECS[k].outcome == 2'd0) begin
                    chk("R7 R4 held bsy", bsy_out, 1);
                    chk("R7 held oe", data_oe, 1);
                    chk("R7 lost", arb_lost, 0);
                    chk("R7 data", data_out, VECS[k].latch);
                end else begin
                    chk("R8 bsy released", bsy_out, 0);
                    chk("R8 data zero", data_out, 0);
                    chk("R8 lost", arb_lost, 1);
                end
            end
            idle_req();
        end

        // R2: conflict, then SEL clears while arb_req stays high
        own_id = 3'd6; out_latch = 8'h40; others = 8'h00;
        bus_sel_in = 1'b1; own_sel_assert = 1'b0;
        raise_req();
        chk("R3 lost again", arb_lost, 1);
        bus_sel_in = 1'b0;
        repeat (30) @(negedge clk);
        chk("R2 no restart bsy", bsy_out, 0);
        chk("R2 no restart busy", arb_busy, 0);
        idle_req();

        // R2 and R11: held bus, level high stays held, then release
        raise_req();
        run_wait("R6", 22);
        chk("R7 won", bsy_out, 1);
        repeat (30) @(negedge clk);
        chk("R2 held stays", bsy_out, 1);
        chk("R2 held no busy", arb_busy, 0);
        arb_req = 1'b0;
        @(negedge clk);
        chk("R11 released bsy", bsy_out, 0);
        chk("R11 released oe", data_oe, 0);
        repeat (2) @(negedge clk);

        // R9 abort during wait
        raise_req();
        repeat (5) @(negedge clk);
        arb_req = 1'b0;
        @(negedge clk);
        chk("R9 bsy", bsy_out, 0);
        chk("R9 busy", arb_busy, 0);
        chk("R9 lost", arb_lost, 0);
        repeat (2) @(negedge clk);

        // R6 factor 1 -> N=11
        conv_in = 4'd1; conv_we = 1'b1;
        @(negedge clk);
        conv_we = 1'b0;
        raise_req();
        run_wait("R6 f1", 11);
        chk("R6 f1 decided", arb_busy, 0);
        chk("R6 f1 won", bsy_out, 1);
        idle_req();

        // R10 factor 0 -> decided on first edge after start
        conv_in = 4'd0; conv_we = 1'b1;
        @(negedge clk);
        conv_we = 1'b0;
        others = 8'h80;
        raise_req();
        chk("R10 busy after start", arb_busy, 1);
        @(negedge clk);
        chk("R10 decided", arb_busy, 0);
        chk("R10 lost", arb_lost, 1);
        chk("R10 released", bsy_out, 0);
        idle_req();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule